// File: doc/BRIEF.md
# Vectored Multi-Bank Interrupt Controller

This controller takes a wide set of interrupt inputs, arranged as banks of 32, and combines them into a single interrupt request for a processor. Software reaches it over a simple 32-bit register bus. It can enable each source, block it with a separate mask bit, read the pending state of each bank, and read a vector register. The vector register names the lowest-numbered source that is active.

Source 0 is special: it is an external line with a selectable trigger. It is latched on that trigger and stays pending until software clears it. Every other source is level-sensitive, and its pending bit follows its input one clock later. The vector register reads zero both when nothing is active and when source 0 wins. Software separates the two cases by reading bit 0 of the first pending bank.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, all enable, mask, protection and trigger-control registers are zero, source 0 is not pending, `irq_o` is low and the vector register reads 0.
- R2: Register reads are registered: `rdata_o` holds the value of the location addressed by a read request one clock after that request is sampled. Offsets: vector 0x00, protection 0x08, trigger control 0x0C, pending bank b at 0x10+4b, FIQ pending bank b at 0x20+4b, enable bank b at 0x40+4b, mask bank b at 0x50+4b.
- R3: The pending bit of each source n ≥ 1 equals that source's input as sampled on the previous clock. Source n appears in bank n/32 at bit n%32.
- R4: The trigger type of source 0 is set by trigger control bits [1:0]: 0 is low level, 1 is high level, 2 is a falling edge, 3 is a rising edge. A trigger latches pending bit 0, and the bit stays set after the input returns to idle.
- R5: Writing a 1 to bit 0 of pending bank 0 clears the source 0 latch unless a trigger is present on that same clock, in which case the bit stays set. Writing 0 leaves the latch unchanged. Writing to the pending bits of level sources has no effect.
- R6: A source is active when it is pending, its enable bit is 1 and its mask bit is 0. `irq_o` is the OR of all active sources.
- R7: The vector register returns the index of the lowest-numbered active source in bits [8:2], with all other bits zero. It reads 0 when no source is active.
- R8: Protection bit 0 and trigger control bits [1:0] store the values written to them. The other bits of these registers read as zero.
- R9: Reads of unmapped or unaligned addresses, and reads of the FIQ pending banks, return zero. Writes to the vector register, to the FIQ pending banks and to unmapped addresses change nothing.
- R10: A write to an enable bank or a mask bank replaces all 32 bits of that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_BANKS*32 | Interrupt source inputs; bit 0 is the external line |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one clock after the read request |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default of three banks, so source indices reach 95 and the vector field is filled up to bit 8. It drives sources in each of the three banks at the same time, so the lowest-index selection is tested across bank boundaries, including the mask and enable of one bank changing the winner. The bench also steps source 0 through all four trigger types. It clears the latch both while the trigger is still present and after the line has returned to idle.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  localparam int unsigned OFF_VEC  = 'h00;
  localparam int unsigned OFF_PROT = 'h08;
  localparam int unsigned OFF_TRIG = 'h0C;
  localparam int unsigned OFF_PEND = 'h10;
  localparam int unsigned OFF_FIQ  = 'h20;
  localparam int unsigned OFF_EN   = 'h40;
  localparam int unsigned OFF_MASK = 'h50;
endpackage

// File: rtl/vic_src0_latch.sv
module vic_src0_latch
  import vic_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  trig_e mode_i,
  input  logic  line_i,
  input  logic  clr_i,
  output logic  pend_o
);
  logic prev_q, pend_q, hit;

  always_comb begin
    unique case (mode_i)
      TRIG_LOW:  hit = ~line_i;
      TRIG_HIGH: hit = line_i;
      TRIG_FALL: hit = prev_q & ~line_i;
      default:   hit = ~prev_q & line_i;
    endcase
  end

  // a trigger in the clearing cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      pend_q <= hit | (pend_q & ~clr_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int unsigned N    = 96,
  parameter int unsigned IDXW = $clog2(N)
) (
  input  logic [N-1:0]    act_i,
  output logic            valid_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) idx_o = IDXW'(i);
    end
  end

  assign valid_o = |act_i;
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,  // 1..4, bounded by bank spacing
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BANKS*WORD_W-1:0] src_i,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [WORD_W-1:0]           wdata_i,
  output logic [WORD_W-1:0]           rdata_o,
  output logic                        irq_o
);
  localparam int unsigned NUM_SRC = NUM_BANKS * WORD_W;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);

  logic [NUM_BANKS-1:0][WORD_W-1:0] en_q, mask_q;
  logic [NUM_SRC-1:1]               lvl_q;
  logic                             prot_q;
  trig_e                            trig_q;
  logic                             pend0, clr0;
  logic [NUM_SRC-1:0]               pend_all, en_flat, mask_flat, act;
  logic                             vec_valid;
  logic [IDX_W-1:0]                 vec_idx;
  logic [WORD_W-1:0]                vec_word, rd_d;
  logic                             wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign clr0 = wr & (addr_i == ADDR_W'(OFF_PEND)) & wdata_i[0];

  vic_src0_latch u_src0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (trig_q),
    .line_i (src_i[0]),
    .clr_i  (clr0),
    .pend_o (pend0)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      prot_q <= 1'b0;
      trig_q <= TRIG_LOW;
    end else begin
      lvl_q <= src_i[NUM_SRC-1:1];
      if (wr && addr_i == ADDR_W'(OFF_PROT)) prot_q <= wdata_i[0];
      if (wr && addr_i == ADDR_W'(OFF_TRIG)) trig_q <= trig_e'(wdata_i[1:0]);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[b]   <= '0;
        mask_q[b] <= '0;
      end else begin
        if (wr && addr_i == ADDR_W'(OFF_EN + 4 * b))   en_q[b]   <= wdata_i;
        if (wr && addr_i == ADDR_W'(OFF_MASK + 4 * b)) mask_q[b] <= wdata_i;
      end
    end
    assign en_flat[b*WORD_W +: WORD_W]   = en_q[b];
    assign mask_flat[b*WORD_W +: WORD_W] = mask_q[b];
  end

  assign pend_all = {lvl_q, pend0};
  assign act      = pend_all & en_flat & ~mask_flat;

  vic_prio_enc #(.N(NUM_SRC), .IDXW(IDX_W)) u_prio (
    .act_i   (act),
    .valid_o (vec_valid),
    .idx_o   (vec_idx)
  );

  assign irq_o    = vec_valid;
  assign vec_word = vec_valid ? WORD_W'({vec_idx, 2'b00}) : '0;

  always_comb begin
    rd_d = '0;
    if (addr_i == ADDR_W'(OFF_VEC))  rd_d = vec_word;
    if (addr_i == ADDR_W'(OFF_PROT)) rd_d = WORD_W'(prot_q);
    if (addr_i == ADDR_W'(OFF_TRIG)) rd_d = WORD_W'(trig_q);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == ADDR_W'(OFF_PEND + 4 * b)) rd_d = pend_all[b*WORD_W +: WORD_W];
      if (addr_i == ADDR_W'(OFF_EN + 4 * b))   rd_d = en_q[b];
      if (addr_i == ADDR_W'(OFF_MASK + 4 * b)) rd_d = mask_q[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_d;
  end
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
  import vic_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned NUM_SRC  = NUM_BANKS * WORD_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [WORD_W-1:0]  wdata_i,
  input logic [WORD_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic [NUM_SRC-1:0] mask_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_level_track_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    pend_i[NUM_SRC-1:1] == $past(src_i[NUM_SRC-1:1]));

  assert_src0_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[0] && !(req_i && we_i && addr_i == ADDR_W'(OFF_PEND) && wdata_i[0])) |=> pend_i[0]);

  assert_quiet_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(en_i) == 0) |-> !irq_o);

  assert_quiet_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(mask_i) == NUM_SRC) |-> !irq_o);

  assert_empty_vector_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(OFF_VEC) && !irq_o) |=> rdata_o == '0);

  assert_enable_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_EN)) |=> en_i[WORD_W-1:0] == $past(wdata_i));

  assert_unaligned_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[1:0] != 2'b00) |=> rdata_o == '0);
endmodule

bind vic_ctrl vic_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .pend_i  (pend_all),
  .en_i    (en_flat),
  .mask_i  (mask_flat)
);

// File: tb/vic_ctrl_bench.sv
`timescale 1ns/1ps
module vic_ctrl_bench;
  localparam int unsigned NB = 3;
  localparam int unsigned NS = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = NS'(1);
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int            n_chk = 0, n_err = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  vic_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) u_vic_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .src_i (src),
    .req_i (req), .we_i (we), .addr_i (addr), .wdata_i (wdata),
    .rdata_o (rdata), .irq_o (irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic set_src(logic [NS-1:0] v);
    @(negedge clk); src = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    rd(8'h40, d); chk("R1 enable0", d, 0);
    rd(8'h58, d); chk("R1 mask2", d, 0);
    rd(8'h10, d); chk("R1 pend0", d, 0);
    rd(8'h00, d); chk("R1 vector", d, 0);
    rd(8'h08, d); chk("R1 prot", d, 0);
    rd(8'h0C, d); chk("R1 trig", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R8 prot", d, 1);
    wr(8'h0C, 32'hFFFF_FFF3); rd(8'h0C, d); chk("R8 trig", d, 3);
    wr(8'h0C, 0);
    wr(8'h48, 32'hA5A5_0001); rd(8'h48, d); chk("R10 enable2", d, 32'hA5A5_0001);
    wr(8'h54, 32'h1234_5678); rd(8'h54, d); chk("R10 mask1", d, 32'h1234_5678);
    rd(8'h48, d); chk("R2 enable2 unchanged", d, 32'hA5A5_0001);
    wr(8'h48, 0); wr(8'h54, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_src(src | (NS'(1) << 37));
    rd(8'h14, d); chk("R3 pend1 bit5", d, 32'h20);
    chk("R6 disabled irq", 32'(irq), 0);
    wr(8'h14, 32'h20); rd(8'h14, d); chk("R5 level w1c ignored", d, 32'h20);
    set_src(NS'(1));
    rd(8'h14, d); chk("R3 pend1 follows low", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    for (int b = 0; b < 3; b++) wr(8'(8'h40 + 4 * b), 32'hFFFF_FFFF);
    set_src(NS'(1) | (NS'(1) << 5) | (NS'(1) << 40) | (NS'(1) << 70));
    chk("R6 irq on", 32'(irq), 1);
    rd(8'h00, d); chk("R7 vector 5", d, 20);
    wr(8'h50, 32'h20); rd(8'h00, d); chk("R6 R7 masked 5 -> 40", d, 160);
    wr(8'h44, 0);      rd(8'h00, d); chk("R6 R7 bank1 off -> 70", d, 280);
    wr(8'h48, 0);
    chk("R6 all blocked", 32'(irq), 0);
    rd(8'h00, d); chk("R7 none active", d, 0);
    wr(8'h50, 0); wr(8'h40, 0);
    set_src(NS'(1) | (NS'(1) << 95));
    wr(8'h48, 32'h8000_0000);
    rd(8'h00, d); chk("R7 vector 95", d, 380);
    wr(8'h48, 0);
    set_src(NS'(1));
  endtask

  task automatic t_src0();
    logic [31:0] d;
    wr(8'h0C, 3);
    set_src(NS'(0)); set_src(NS'(1));
    set_src(NS'(0));
    rd(8'h10, d); chk("R4 rising latched", d, 1);
    set_src(NS'(1));
    wr(8'h40, 1);
    chk("R6 src0 irq", 32'(irq), 1);
    rd(8'h00, d); chk("R7 src0 vector zero", d, 0);
    wr(8'h10, 0); rd(8'h10, d); chk("R5 write0 keeps", d, 1);
    wr(8'h10, 1); rd(8'h10, d); chk("R5 w1c clears", d, 0);
    chk("R5 irq after clear", 32'(irq), 0);
    wr(8'h0C, 2);
    set_src(NS'(0)); set_src(NS'(1));
    rd(8'h10, d); chk("R4 falling latched", d, 1);
    wr(8'h10, 1);
    wr(8'h0C, 1);
    rd(8'h10, d); chk("R4 high level latched", d, 1);
    wr(8'h10, 1); rd(8'h10, d); chk("R5 trigger wins clear", d, 1);
    wr(8'h0C, 0);
    wr(8'h10, 1); rd(8'h10, d); chk("R4 low idle clear", d, 0);
    set_src(NS'(0)); set_src(NS'(1));
    rd(8'h10, d); chk("R4 low level held", d, 1);
    wr(8'h10, 1); rd(8'h10, d); chk("R5 low cleared", d, 0);
    wr(8'h40, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF); rd(8'h00, d); chk("R9 vector write ignored", d, 0);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); chk("R9 fiq reads zero", d, 0);
    wr(8'h60, 32'hFFFF_FFFF); rd(8'h40, d); chk("R9 unmapped write", d, 0);
    rd(8'h04, d); chk("R9 hole read", d, 0);
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h45, d); chk("R9 unaligned read", d, 0);
    rd(8'h60, d); chk("R9 unmapped read", d, 0);
    wr(8'h44, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level();
    t_prio();
    t_src0();
    t_ignore();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule